// File: doc/BRIEF.md
# Reference Clock Comparison Counter

This block checks an external 10 MHz reference against a 10 MHz reference made inside the chip from the system clock. Software starts a measurement. A gate window of a programmed number of internal reference periods is then opened. A counter in the external clock domain counts external edges for as long as the window is open. When the window closes, the external count returns to the system domain through a toggle handshake. Both counts are then latched, together with their signed difference, an absent flag and a done flag. Software reads the results to learn whether the external reference is present and how far its frequency is from the internal one. A gate of 10,000,000 internal periods gives a one-second window, and in that window one count of difference equals 0.1 ppm.

The gate level reaches the external domain through a two-flop synchronizer. If the external clock is dead, the handshake never comes back. A bounded wait in the system domain then ends the measurement with a count of zero and the absent flag set. A software select drives one reference output, taken either from the internal divided clock or from the external input.

Top module: `refclk_cmp`

## Requirements
- R1: After a synchronous reset, busy, done and ext_absent are 0, and ext_count, gate_count_q and count_diff are all 0.
- R2: A start pulse sampled while busy is 0 sets busy to 1 and clears done at that same clock edge.
- R3: The gate opens on a rising edge of the internal reference and stays open for exactly N internal periods (N×DIV system cycles). ext_count then equals the number of external rising edges in that window to within ±1, and gate_count_q reports N.
- R4: count_diff is the two's-complement value ext_count − gate_count_q, GATE_W+3 bits wide.
- R5: A measurement ends in a single cycle: busy falls and done rises together. done stays 1 until the next accepted start. ext_count, gate_count_q, count_diff and ext_absent change only in the cycle in which done rises.
- R6: The measurement ends with ext_absent = 1 and ext_count = 0 in two cases: no handshake returns within ACK_WAIT system cycles after the gate closes, or the returned count is zero. count_diff is then −N.
- R7: A start pulse while busy is 1 is ignored. The gate_cycles value taken at the accepted start alone sets the running window.
- R8: With use_ext = 0, ref_out is the internal reference: a square wave of DIV system cycles with DIV/2 high. With use_ext = 1, ref_out follows ext_clk.
- R9: A gate_cycles value of 0 is taken as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the internal reference is clk/DIV |
| rst | input | 1 | Synchronous active-high reset, also brought into the external domain |
| ext_clk | input | 1 | External reference clock under test |
| start | input | 1 | Single-cycle request to begin a measurement |
| gate_cycles | input | GATE_W | Gate length in internal reference periods |
| use_ext | input | 1 | Reference select: 0 internal, 1 external |
| ref_out | output | 1 | Selected reference for downstream use |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Results valid since the last completion |
| ext_absent | output | 1 | External reference found missing |
| gate_count_q | output | GATE_W | Gate length used by the last measurement |
| ext_count | output | GATE_W+2 | External edges counted in the last window |
| count_diff | output | GATE_W+3 | Signed ext_count minus gate_count_q |

## Verification
The hardest case to reach is a measurement with the external clock stopped. The synchronizer flops then freeze mid-window, and the handshake can only end through the bounded wait. The bench stops its external clock generator before a start, waits for that timeout to finish the run, and then restarts the clock. Restarting releases a stale handshake toggle while the block is idle, and the bench checks that this toggle leaves the latched results untouched. A second start is also sent in the middle of a gate window with a different length, to show that the value from the first start is the one kept.

// File: rtl/refclk_cmp_pkg.sv
package refclk_cmp_pkg;
  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_ARM  = 2'd1,
    MS_GATE = 2'd2,
    MS_WAIT = 2'd3
  } meas_state_t;
endpackage

// File: rtl/refclk_cmp_div.sv
module refclk_cmp_div #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst,
  output logic ref_lvl,
  output logic ref_tick
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      ref_lvl  <= 1'b0;
      ref_tick <= 1'b0;
    end else if (phase == CW'(HALF - 1)) begin
      phase    <= '0;
      ref_lvl  <= ~ref_lvl;
      ref_tick <= ~ref_lvl;
    end else begin
      phase    <= phase + 1'b1;
      ref_tick <= 1'b0;
    end
  end
endmodule

// File: rtl/refclk_cmp_ext.sv
module refclk_cmp_ext #(
  parameter int CNT_W = 26
) (
  input  logic             ext_clk,
  input  logic             rst,
  input  logic             gate_lvl,
  output logic [CNT_W-1:0] hold_cnt,
  output logic             ack_tgl
);
  logic             rst_m, rst_e;
  logic             g_s1, g_s2, g_s3;
  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge ext_clk) begin
    rst_m <= rst;
    rst_e <= rst_m;
  end

  always_ff @(posedge ext_clk) begin
    if (rst_e) begin
      g_s1     <= 1'b0;
      g_s2     <= 1'b0;
      g_s3     <= 1'b0;
      run_cnt  <= '0;
      hold_cnt <= '0;
      ack_tgl  <= 1'b0;
    end else begin
      g_s1 <= gate_lvl;
      g_s2 <= g_s1;
      g_s3 <= g_s2;
      if (g_s2 && !g_s3)
        run_cnt <= CNT_W'(1);
      else if (g_s2 && (run_cnt != '1))
        run_cnt <= run_cnt + 1'b1;
      if (!g_s2 && g_s3) begin
        hold_cnt <= run_cnt;
        ack_tgl  <= ~ack_tgl;
      end
    end
  end
endmodule

// File: rtl/refclk_cmp_ctl.sv
module refclk_cmp_ctl
  import refclk_cmp_pkg::*;
#(
  parameter int GATE_W   = 24,
  parameter int ACK_WAIT = 255
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [GATE_W-1:0]        gate_cycles,
  input  logic                     ref_tick,
  input  logic                     ack_edge,
  input  logic [GATE_W+1:0]        hold_cnt,
  output logic                     gate_lvl,
  output logic                     busy,
  output logic                     done,
  output logic                     ext_absent,
  output logic [GATE_W-1:0]        gate_count_q,
  output logic [GATE_W+1:0]        ext_count,
  output logic signed [GATE_W+2:0] count_diff
);
  localparam int CNT_W  = GATE_W + 2;
  localparam int DIFF_W = GATE_W + 3;
  localparam int WAIT_W = $clog2(ACK_WAIT + 1);

  meas_state_t       state;
  logic [GATE_W-1:0] len_q;
  logic [GATE_W-1:0] tick_cnt;
  logic [WAIT_W-1:0] wait_cnt;
  logic              finish;
  logic [CNT_W-1:0]  fin_cnt;

  always_comb begin
    finish  = 1'b0;
    fin_cnt = '0;
    if (state == MS_WAIT) begin
      if (ack_edge) begin
        finish  = 1'b1;
        fin_cnt = hold_cnt;
      end else if (wait_cnt == WAIT_W'(ACK_WAIT - 1)) begin
        finish  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= MS_IDLE;
      len_q        <= '0;
      tick_cnt     <= '0;
      wait_cnt     <= '0;
      gate_lvl     <= 1'b0;
      busy         <= 1'b0;
      done         <= 1'b0;
      ext_absent   <= 1'b0;
      gate_count_q <= '0;
      ext_count    <= '0;
      count_diff   <= '0;
    end else begin
      case (state)
        MS_IDLE: if (start) begin
          len_q <= (gate_cycles == '0) ? GATE_W'(1) : gate_cycles;
          busy  <= 1'b1;
          done  <= 1'b0;
          state <= MS_ARM;
        end
        MS_ARM: if (ref_tick) begin
          gate_lvl <= 1'b1;
          tick_cnt <= '0;
          state    <= MS_GATE;
        end
        MS_GATE: if (ref_tick) begin
          if (tick_cnt == len_q - 1'b1) begin
            gate_lvl <= 1'b0;
            wait_cnt <= '0;
            state    <= MS_WAIT;
          end else begin
            tick_cnt <= tick_cnt + 1'b1;
          end
        end
        MS_WAIT: begin
          if (finish) begin
            ext_count    <= fin_cnt;
            ext_absent   <= (fin_cnt == '0);
            gate_count_q <= len_q;
            count_diff   <= $signed({1'b0, fin_cnt}) -
                            $signed({{(DIFF_W - GATE_W){1'b0}}, len_q});
            busy         <= 1'b0;
            done         <= 1'b1;
            state        <= MS_IDLE;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        default: state <= MS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/refclk_cmp.sv
module refclk_cmp #(
  parameter int DIV      = 10,
  parameter int GATE_W   = 24,
  parameter int ACK_WAIT = 255
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ext_clk,
  input  logic                     start,
  input  logic [GATE_W-1:0]        gate_cycles,
  input  logic                     use_ext,
  output logic                     ref_out,
  output logic                     busy,
  output logic                     done,
  output logic                     ext_absent,
  output logic [GATE_W-1:0]        gate_count_q,
  output logic [GATE_W+1:0]        ext_count,
  output logic signed [GATE_W+2:0] count_diff
);
  localparam int CNT_W = GATE_W + 2;

  logic             int_ref, ref_tick, gate_lvl;
  logic [CNT_W-1:0] hold_cnt;
  logic             ack_tgl;
  logic             a_s1, a_s2, a_s3;
  logic             ack_edge;

  refclk_cmp_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst(rst), .ref_lvl(int_ref), .ref_tick(ref_tick)
  );

  refclk_cmp_ext #(.CNT_W(CNT_W)) u_ext (
    .ext_clk(ext_clk), .rst(rst), .gate_lvl(gate_lvl),
    .hold_cnt(hold_cnt), .ack_tgl(ack_tgl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_s1 <= 1'b0;
      a_s2 <= 1'b0;
      a_s3 <= 1'b0;
    end else begin
      a_s1 <= ack_tgl;
      a_s2 <= a_s1;
      a_s3 <= a_s2;
    end
  end
  assign ack_edge = a_s2 ^ a_s3;

  refclk_cmp_ctl #(.GATE_W(GATE_W), .ACK_WAIT(ACK_WAIT)) u_ctl (
    .clk(clk), .rst(rst), .start(start), .gate_cycles(gate_cycles),
    .ref_tick(ref_tick), .ack_edge(ack_edge), .hold_cnt(hold_cnt),
    .gate_lvl(gate_lvl), .busy(busy), .done(done), .ext_absent(ext_absent),
    .gate_count_q(gate_count_q), .ext_count(ext_count), .count_diff(count_diff)
  );

  assign ref_out = use_ext ? ext_clk : int_ref;
endmodule

// File: rtl/refclk_cmp_chk.sv
module refclk_cmp_chk #(
  parameter int GATE_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              ext_absent,
  input logic [GATE_W+1:0] ext_count
);
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R5
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done)); // R2
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R7
  AST_END_SETS_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !$rose(done) |-> ($stable(ext_count) && $stable(ext_absent))); // R5
  AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (rst)
    ext_absent |-> (ext_count == '0)); // R6
endmodule

bind refclk_cmp refclk_cmp_chk #(.GATE_W(GATE_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .ext_absent(ext_absent), .ext_count(ext_count)
);

// File: tb/refclk_cmp_test.sv
`timescale 1ns/100ps
module refclk_cmp_test;
  localparam int DIV = 20;
  localparam int GW  = 16;
  localparam real TSYS = 5.0;

  logic clk = 1'b0, rst = 1'b1, ext_clk = 1'b0, start = 1'b0, use_ext = 1'b0;
  logic [GW-1:0]        gate_cycles = '0;
  logic                 ref_out, busy, done, ext_absent;
  logic [GW-1:0]        gate_count_q;
  logic [GW+1:0]        ext_count;
  logic signed [GW+2:0] count_diff;

  int  tests = 0, fails = 0;
  bit  ext_on = 1'b1;
  real ext_half = 50.0;
  bit  model_on = 1'b0;

  refclk_cmp #(.DIV(DIV), .GATE_W(GW), .ACK_WAIT(255)) uut (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .start(start),
    .gate_cycles(gate_cycles), .use_ext(use_ext), .ref_out(ref_out),
    .busy(busy), .done(done), .ext_absent(ext_absent),
    .gate_count_q(gate_count_q), .ext_count(ext_count), .count_diff(count_diff)
  );

  always #2.5 clk = ~clk;

  initial begin
    #1.7;
    forever begin
      if (ext_on) begin
        #(ext_half) ext_clk = ~ext_clk;
      end else begin
        ext_clk = 1'b0;
        #5;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle model of handshake and result holding, sampled at negedge
  bit p_start, p_busy, p_done, p_abs;
  longint p_cnt, p_gate, p_diff;
  always @(negedge clk) begin
    if (model_on) begin
      if (p_start && !p_busy)
        chk(busy && !done, "R2", "busy/done after accepted start", {busy, done}, 2);
      if (p_busy && !busy)
        chk(done, "R5", "done with busy fall", done, 1);
      if (!done || p_done) begin
        chk(ext_count == p_cnt && gate_count_q == p_gate &&
            longint'(count_diff) == p_diff && ext_absent == p_abs,
            "R5", "results held", ext_count, p_cnt);
      end
    end
    p_start = start; p_busy = busy; p_done = done; p_abs = ext_absent;
    p_cnt = ext_count; p_gate = gate_count_q; p_diff = longint'(count_diff);
    if (!rst) model_on = 1'b1;
  end

  task automatic pulse_start(input int n);
    @(negedge clk); #1;
    gate_cycles = GW'(n);
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    #2;
  endtask

  task automatic measure(input int n, input real period);
    real expv;
    int  eff;
    ext_half = period / 2.0;
    repeat (40) @(negedge clk);
    eff = (n == 0) ? 1 : n;
    pulse_start(n);
    wait_done();
    expv = eff * DIV * TSYS / period;
    chk(done == 1'b1, "R5", "done after measurement", done, 1);
    chk(gate_count_q == GW'(eff), (n == 0) ? "R9" : "R3", "gate count", gate_count_q, eff);
    chk((real'(ext_count) >= expv - 1.5) && (real'(ext_count) <= expv + 1.5),
        "R3", "external count", ext_count, longint'(expv));
    chk(longint'(count_diff) == longint'(ext_count) - eff, "R4", "difference",
        count_diff, longint'(ext_count) - eff);
    chk(ext_absent == 1'b0, "R6", "absent clear with clock", ext_absent, 0);
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int hi, tg;
    logic prv;
    repeat (60) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    chk({busy, done, ext_absent} == 3'b000, "R1", "flags after reset", {busy, done, ext_absent}, 0);
    chk(ext_count == 0 && gate_count_q == 0 && count_diff == 0, "R1", "results after reset",
        ext_count, 0);

    // R8 internal reference shape
    use_ext = 1'b0;
    hi = 0; tg = 0;
    @(negedge clk); prv = ref_out;
    for (int i = 0; i < 2 * DIV; i++) begin
      @(negedge clk);
      if (ref_out) hi++;
      if (ref_out != prv) tg++;
      prv = ref_out;
    end
    chk(hi == DIV, "R8", "internal ref high cycles", hi, DIV);
    chk(tg == 4, "R8", "internal ref transitions", tg, 4);
    use_ext = 1'b1;
    tg = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ref_out != ext_clk) tg++;
    end
    chk(tg == 0, "R8", "external ref mismatches", tg, 0);
    use_ext = 1'b0;

    measure(40, 100.0);
    measure(30, 80.0);
    measure(25, 125.0);
    measure(0, 100.0);

    // R7: second start during a run is ignored
    ext_half = 50.0;
    pulse_start(40);
    repeat (100) @(negedge clk);
    pulse_start(5);
    #1;
    chk(busy && !done, "R7", "still busy after ignored start", {busy, done}, 2);
    wait_done();
    chk(gate_count_q == GW'(40), "R7", "gate length kept", gate_count_q, 40);
    chk(ext_count >= 39 && ext_count <= 41, "R7", "count of first window", ext_count, 40);

    // R6: external clock stopped
    ext_on = 1'b0;
    repeat (20) @(negedge clk);
    pulse_start(10);
    wait_done();
    chk(ext_absent == 1'b1, "R6", "absent flag", ext_absent, 1);
    chk(ext_count == 0, "R6", "absent count", ext_count, 0);
    chk(longint'(count_diff) == -10, "R6", "absent difference", count_diff, -10);
    ext_on = 1'b1;
    repeat (300) @(negedge clk);
    #1;
    chk(ext_absent == 1'b1 && ext_count == 0 && done, "R5", "stale handshake ignored",
        ext_count, 0);

    measure(20, 100.0);
    report();
  end
endmodule